// File: doc/BRIEF.md
# Virtualization Mode Entry/Exit Controller

This block holds the virtualization state of one processor core: outside virtualization, in monitor (root) operation, or in guest (non-root) operation. The core presents an enter or a leave request as a single-cycle strobe, together with its privilege level, its operating-mode flags, its feature-control word, the 64-bit region pointer and the 32-bit revision word already fetched from that pointer. The block runs an ordered chain of checks and reports exactly one outcome one cycle later: undefined-opcode fault, general-protection fault, trap to the monitor, fail-invalid, fail-valid or success.

A successful enter moves the core into monitor operation. It sets the current-structure pointer to all ones, blocks INIT, disables A20 masking and clears address-range monitoring. A successful leave returns the core to the outside state, unblocks INIT and re-enables A20 masking. A trap always lands the core in monitor operation. A separate launch strobe moves the core from monitor to guest operation, so that the guest-side rules can be exercised. Memory access, page faults and segment checks belong to other blocks.

Top module: `vmode_ctrl`

## Requirements
- R1: After reset, mode is 00 (outside), done is 0, result is 0, init_blocked, a20_disabled and mon_clear are 0, and cur_ptr is 0. Mode encoding: 00 outside, 01 monitor (root), 10 guest (non-root).
- R2: A request strobe in one cycle gives done=1 in the next cycle, with exactly one result bit set. The bits are: bit0 undefined-opcode, bit1 general-protection, bit2 trap, bit3 fail-invalid, bit4 fail-valid, bit5 success. In a cycle with no request strobe, done is 0 and result is 0 in the next cycle.
- R3: Either request gives undefined-opcode, ahead of every other check, when v86 is 1, or when long_mode is 1 and cs_long is 0.
- R4: An enter request also gives undefined-opcode, ahead of all later checks, when operand_is_reg is 1, when cr4_enable is 0 or when cr0_pe is 0.
- R5: An enter request while outside gives general-protection when cpl is nonzero, when a20m_active is 1, when fixed_ok is 0, or when feat_ctrl bit 0 or feat_ctrl bit 2 is 0. Other feat_ctrl bits have no effect.
- R6: Past the R5 checks, an enter request gives fail-invalid in any of these cases: region_ptr bits 11:0 are not all zero; region_ptr has any bit at or above PA_W (default 52) set; core_64 is 0 and region_ptr bits 63:32 are not all zero.
- R7: Past R6, an enter request gives fail-invalid when rev_word differs from REV_ID (default 32'h0000_0012). Otherwise it gives success.
- R8: A successful enter sets mode to 01, cur_ptr to all ones, and init_blocked and a20_disabled to 1, in the same cycle as done. mon_clear is 1 for that one cycle only.
- R9: An enter request in guest mode gives trap and sets mode to 01. In monitor mode it gives general-protection when cpl is nonzero and fail-valid otherwise.
- R10: A leave request gives undefined-opcode while outside. In guest mode it gives trap and sets mode to 01. In monitor mode, the checks run in this order: general-protection when cpl is nonzero, then fail-valid when dual_mon is 1, then success. Success sets mode to 00, clears init_blocked and a20_disabled, and pulses mon_clear.
- R11: launch_guest in a cycle with no request, while mode is 01, sets mode to 10 in the next cycle. launch_guest is ignored in any other mode and in any cycle that carries a request.
- R12: When req_enter and req_leave are both 1, only the enter request is evaluated.
- R13: An outcome other than success or trap leaves mode, init_blocked, a20_disabled and cur_ptr unchanged, and keeps mon_clear at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_enter | input | 1 | Enter request strobe |
| req_leave | input | 1 | Leave request strobe |
| launch_guest | input | 1 | Move from monitor to guest operation |
| cpl | input | 2 | Current privilege level |
| v86 | input | 1 | Core in virtual-8086 mode |
| long_mode | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| operand_is_reg | input | 1 | Enter operand is a register |
| cr4_enable | input | 1 | Virtualization enable bit in CR4 |
| cr0_pe | input | 1 | Protected mode enabled |
| a20m_active | input | 1 | A20 mask in force |
| fixed_ok | input | 1 | CR0/CR4 fixed-bit constraints met |
| feat_ctrl | input | FC_W | Feature-control word (bit0 lock, bit2 enable) |
| dual_mon | input | 1 | Dual-monitor treatment active |
| core_64 | input | 1 | Core supports 64-bit addressing |
| region_ptr | input | 64 | Region pointer operand |
| rev_word | input | 32 | Revision word fetched at region_ptr |
| done | output | 1 | Outcome valid strobe |
| result | output | 6 | One-hot outcome |
| mode | output | 2 | Virtualization mode state |
| init_blocked | output | 1 | INIT signals blocked |
| a20_disabled | output | 1 | A20 masking blocked and disabled |
| mon_clear | output | 1 | Clear address-range monitoring pulse |
| cur_ptr | output | 64 | Current-structure pointer |

## Verification
The bench aims at the edges of the pointer check: the first bit past the page offset, bit PA_W itself, and a high bit that is legal only on a 64-bit core. A design that is off by one in its width mask would accept a bad pointer or refuse a good one. It also targets the order of the checks. It sets several faults at once, for example v86 together with a bad CPL, and dual-monitor together with a nonzero CPL. A chain in the wrong order reports the weaker fault. Launch pulses that arrive with a request, or while outside, show up as a wrong mode on a later request. Simultaneous enter and leave strobes show up as a leave outcome where an enter outcome was expected. Feature-control bit 1 cleared on its own checks that the lock and enable positions are not swapped or widened.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  localparam int PTR_W     = 64;
  localparam int REV_W     = 32;
  localparam int PAGE_BITS = 12;
  localparam int RES_W     = 6;

  localparam int RES_UD    = 0;
  localparam int RES_GP    = 1;
  localparam int RES_TRAP  = 2;
  localparam int RES_FINV  = 3;
  localparam int RES_FVAL  = 4;
  localparam int RES_SUCC  = 5;

  typedef enum logic [1:0] {
    MODE_OUT   = 2'b00,
    MODE_ROOT  = 2'b01,
    MODE_GUEST = 2'b10
  } vmode_e;

  // Mode combinations in which neither request is recognized.
  function automatic logic legacy_block(input logic v86, input logic lm, input logic csl);
    return v86 | (lm & ~csl);
  endfunction

  // Region pointer legality: page aligned, within address width, 32-bit core limit.
  function automatic logic ptr_legal(input logic [PTR_W-1:0] p, input logic core64,
                                     input int pa_w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PTR_W; i++) begin
      if (p[i]) begin
        if (i < PAGE_BITS) ok = 1'b0;
        if (i >= pa_w) ok = 1'b0;
        if (!core64 && i >= 32) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  function automatic logic [RES_W-1:0] res_bit(input int idx);
    logic [RES_W-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/vmode_enter_eval.sv
module vmode_enter_eval
  import vmode_pkg::*;
#(
  parameter int                PA_W   = 52,
  parameter logic [REV_W-1:0]  REV_ID = 32'h0000_0012,
  parameter int                FC_W   = 8
) (
  input  logic [1:0]       mode,
  input  logic [1:0]       cpl,
  input  logic             v86,
  input  logic             long_mode,
  input  logic             cs_long,
  input  logic             operand_is_reg,
  input  logic             cr4_enable,
  input  logic             cr0_pe,
  input  logic             a20m_active,
  input  logic             fixed_ok,
  input  logic [FC_W-1:0]  feat_ctrl,
  input  logic             core_64,
  input  logic [PTR_W-1:0] region_ptr,
  input  logic [REV_W-1:0] rev_word,
  output logic             ud_hit,
  output logic             gp_outside,
  output logic             ptr_bad,
  output logic             rev_bad,
  output logic [RES_W-1:0] res
);

  localparam int LOCK_BIT = 0;
  localparam int ENA_BIT  = 2;

  assign ud_hit     = operand_is_reg | ~cr4_enable | ~cr0_pe |
                      legacy_block(v86, long_mode, cs_long);
  assign gp_outside = (cpl != 2'd0) | a20m_active | ~fixed_ok |
                      ~feat_ctrl[LOCK_BIT] | ~feat_ctrl[ENA_BIT];
  assign ptr_bad    = ~ptr_legal(region_ptr, core_64, PA_W);
  assign rev_bad    = (rev_word != REV_ID);

  always_comb begin
    res = '0;
    if (ud_hit) begin
      res = res_bit(RES_UD);
    end else if (mode == MODE_OUT) begin
      if (gp_outside)   res = res_bit(RES_GP);
      else if (ptr_bad) res = res_bit(RES_FINV);
      else if (rev_bad) res = res_bit(RES_FINV);
      else              res = res_bit(RES_SUCC);
    end else if (mode == MODE_GUEST) begin
      res = res_bit(RES_TRAP);
    end else if (cpl != 2'd0) begin
      res = res_bit(RES_GP);
    end else begin
      res = res_bit(RES_FVAL);
    end
  end

endmodule

// File: rtl/vmode_leave_eval.sv
module vmode_leave_eval
  import vmode_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [1:0]       cpl,
  input  logic             v86,
  input  logic             long_mode,
  input  logic             cs_long,
  input  logic             dual_mon,
  output logic             ud_hit,
  output logic [RES_W-1:0] res
);

  assign ud_hit = (mode == MODE_OUT) | legacy_block(v86, long_mode, cs_long);

  always_comb begin
    res = '0;
    if (ud_hit)                  res = res_bit(RES_UD);
    else if (mode == MODE_GUEST) res = res_bit(RES_TRAP);
    else if (cpl != 2'd0)        res = res_bit(RES_GP);
    else if (dual_mon)           res = res_bit(RES_FVAL);
    else                         res = res_bit(RES_SUCC);
  end

endmodule

// File: rtl/vmode_state.sv
module vmode_state
  import vmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_req,
  input  logic             pick_enter,
  input  logic [RES_W-1:0] res_enter,
  input  logic [RES_W-1:0] res_leave,
  input  logic             launch_guest,
  output logic [1:0]       mode,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             init_blocked,
  output logic             a20_disabled,
  output logic             mon_clear,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             evt_success,
  output logic             evt_trap,
  output logic             evt_launch
);

  logic [RES_W-1:0] sel_res;

  assign sel_res     = pick_enter ? res_enter : res_leave;
  assign evt_success = take_req & sel_res[RES_SUCC];
  assign evt_trap    = take_req & sel_res[RES_TRAP];
  assign evt_launch  = ~take_req & launch_guest & (mode == MODE_ROOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= MODE_OUT;
      done         <= 1'b0;
      result       <= '0;
      init_blocked <= 1'b0;
      a20_disabled <= 1'b0;
      mon_clear    <= 1'b0;
      cur_ptr      <= '0;
    end else begin
      done      <= take_req;
      result    <= take_req ? sel_res : '0;
      mon_clear <= evt_success;
      if (evt_success && pick_enter) begin
        mode         <= MODE_ROOT;
        cur_ptr      <= '1;
        init_blocked <= 1'b1;
        a20_disabled <= 1'b1;
      end else if (evt_success) begin
        mode         <= MODE_OUT;
        init_blocked <= 1'b0;
        a20_disabled <= 1'b0;
      end else if (evt_trap) begin
        mode <= MODE_ROOT;
      end else if (evt_launch) begin
        mode <= MODE_GUEST;
      end
    end
  end

endmodule

// File: rtl/vmode_ctrl.sv
module vmode_ctrl
  import vmode_pkg::*;
#(
  parameter int                PA_W   = 52,
  parameter logic [REV_W-1:0]  REV_ID = 32'h0000_0012,
  parameter int                FC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_enter,
  input  logic             req_leave,
  input  logic             launch_guest,
  input  logic [1:0]       cpl,
  input  logic             v86,
  input  logic             long_mode,
  input  logic             cs_long,
  input  logic             operand_is_reg,
  input  logic             cr4_enable,
  input  logic             cr0_pe,
  input  logic             a20m_active,
  input  logic             fixed_ok,
  input  logic [FC_W-1:0]  feat_ctrl,
  input  logic             dual_mon,
  input  logic             core_64,
  input  logic [PTR_W-1:0] region_ptr,
  input  logic [REV_W-1:0] rev_word,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [1:0]       mode,
  output logic             init_blocked,
  output logic             a20_disabled,
  output logic             mon_clear,
  output logic [PTR_W-1:0] cur_ptr
);

  logic [RES_W-1:0] res_enter;
  logic [RES_W-1:0] res_leave;
  logic             en_ud;
  logic             en_gp;
  logic             en_ptr_bad;
  logic             en_rev_bad;
  logic             lv_ud;
  logic             take_req;
  logic             evt_success;
  logic             evt_trap;
  logic             evt_launch;

  assign take_req = req_enter | req_leave;

  vmode_enter_eval #(.PA_W(PA_W), .REV_ID(REV_ID), .FC_W(FC_W)) u_enter (
    .mode           (mode),
    .cpl            (cpl),
    .v86            (v86),
    .long_mode      (long_mode),
    .cs_long        (cs_long),
    .operand_is_reg (operand_is_reg),
    .cr4_enable     (cr4_enable),
    .cr0_pe         (cr0_pe),
    .a20m_active    (a20m_active),
    .fixed_ok       (fixed_ok),
    .feat_ctrl      (feat_ctrl),
    .core_64        (core_64),
    .region_ptr     (region_ptr),
    .rev_word       (rev_word),
    .ud_hit         (en_ud),
    .gp_outside     (en_gp),
    .ptr_bad        (en_ptr_bad),
    .rev_bad        (en_rev_bad),
    .res            (res_enter)
  );

  vmode_leave_eval u_leave (
    .mode      (mode),
    .cpl       (cpl),
    .v86       (v86),
    .long_mode (long_mode),
    .cs_long   (cs_long),
    .dual_mon  (dual_mon),
    .ud_hit    (lv_ud),
    .res       (res_leave)
  );

  vmode_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_req     (take_req),
    .pick_enter   (req_enter),
    .res_enter    (res_enter),
    .res_leave    (res_leave),
    .launch_guest (launch_guest),
    .mode         (mode),
    .done         (done),
    .result       (result),
    .init_blocked (init_blocked),
    .a20_disabled (a20_disabled),
    .mon_clear    (mon_clear),
    .cur_ptr      (cur_ptr),
    .evt_success  (evt_success),
    .evt_trap     (evt_trap),
    .evt_launch   (evt_launch)
  );

endmodule

// File: rtl/vmode_ctrl_chk.sv
module vmode_ctrl_chk
  import vmode_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_enter,
  input logic             req_leave,
  input logic             launch_guest,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic [1:0]       mode,
  input logic             init_blocked,
  input logic             a20_disabled,
  input logic             mon_clear,
  input logic             en_ud,
  input logic             lv_ud
);

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_enter || req_leave) |=> done);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_enter && !req_leave) |=> (!done && result == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(result) == 1));

  a_r3_ud_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_enter && en_ud) || (!req_enter && req_leave && lv_ud)) |=> result[RES_UD]);

  a_r8_enter_effects: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[RES_SUCC] && mode == MODE_ROOT) |-> (init_blocked && a20_disabled));

  a_r10_leave_effects: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[RES_SUCC] && mode == MODE_OUT) |-> (!init_blocked && !a20_disabled));

  a_r9_trap_to_root: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[RES_TRAP]) |-> (mode == MODE_ROOT));

  a_r13_fail_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !result[RES_SUCC] && !result[RES_TRAP]) |-> ($stable(mode) && !mon_clear));

  a_r8_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mon_clear |-> (done && result[RES_SUCC]));

  a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ROOT && launch_guest && !req_enter && !req_leave) |=> (mode == MODE_GUEST));

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

bind vmode_ctrl vmode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_enter    (req_enter),
  .req_leave    (req_leave),
  .launch_guest (launch_guest),
  .done         (done),
  .result       (result),
  .mode         (mode),
  .init_blocked (init_blocked),
  .a20_disabled (a20_disabled),
  .mon_clear    (mon_clear),
  .en_ud        (en_ud),
  .lv_ud        (lv_ud)
);

// File: tb/test_vmode_ctrl.sv
`timescale 1ns/1ps
module test_vmode_ctrl;

  localparam int  PA_W = 52;
  localparam int  FC_W = 8;
  localparam logic [31:0] REV = 32'h0000_0012;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_enter = 0, req_leave = 0, launch_guest = 0;
  logic [1:0]  cpl = 0;
  logic        v86 = 0, long_mode = 0, cs_long = 0, operand_is_reg = 0;
  logic        cr4_enable = 1, cr0_pe = 1, a20m_active = 0, fixed_ok = 1;
  logic [FC_W-1:0] feat_ctrl = 8'h05;
  logic        dual_mon = 0, core_64 = 1;
  logic [63:0] region_ptr = 64'h1000;
  logic [31:0] rev_word = REV;
  logic        done;
  logic [5:0]  result;
  logic [1:0]  mode;
  logic        init_blocked, a20_disabled, mon_clear;
  logic [63:0] cur_ptr;

  int compared = 0;
  int mismatched = 0;

  // bench model state
  logic [1:0]  m_mode = 2'b00;
  logic        m_init = 0, m_a20 = 0;
  logic [63:0] m_ptr = 64'h0;

  always #4 clk = ~clk;

  vmode_ctrl i_vmode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_enter(req_enter), .req_leave(req_leave),
    .launch_guest(launch_guest), .cpl(cpl), .v86(v86), .long_mode(long_mode),
    .cs_long(cs_long), .operand_is_reg(operand_is_reg), .cr4_enable(cr4_enable),
    .cr0_pe(cr0_pe), .a20m_active(a20m_active), .fixed_ok(fixed_ok),
    .feat_ctrl(feat_ctrl), .dual_mon(dual_mon), .core_64(core_64),
    .region_ptr(region_ptr), .rev_word(rev_word), .done(done), .result(result),
    .mode(mode), .init_blocked(init_blocked), .a20_disabled(a20_disabled),
    .mon_clear(mon_clear), .cur_ptr(cur_ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pointer rule written as masks
  function automatic bit ptr_fine(input logic [63:0] p, input bit c64);
    logic [63:0] hi_mask;
    hi_mask = ~((64'h1 << PA_W) - 64'h1);
    if (!c64) hi_mask = hi_mask | 64'hFFFF_FFFF_0000_0000;
    return ((p & 64'hFFF) == 0) && ((p & hi_mask) == 0);
  endfunction

  // outcome index: 0 ud 1 gp 2 trap 3 finv 4 fval 5 succ
  function automatic int want_enter();
    bit bad_mode = v86 || (long_mode && !cs_long);
    if (bad_mode || operand_is_reg || !cr4_enable || !cr0_pe) return 0;
    case (m_mode)
      2'b00: begin
        if (cpl != 0 || a20m_active || !fixed_ok || !feat_ctrl[0] || !feat_ctrl[2]) return 1;
        if (!ptr_fine(region_ptr, core_64)) return 3;
        if (rev_word != REV) return 3;
        return 5;
      end
      2'b10: return 2;
      default: return (cpl != 0) ? 1 : 4;
    endcase
  endfunction

  function automatic int want_leave();
    if (m_mode == 2'b00 || v86 || (long_mode && !cs_long)) return 0;
    if (m_mode == 2'b10) return 2;
    if (cpl != 0) return 1;
    if (dual_mon) return 4;
    return 5;
  endfunction

  // Called at a negedge; returns at the following negedge after checking.
  task automatic issue(input bit en, input bit lv, input bit lg, input string tag);
    int  w;
    bit  succ;
    req_enter = en; req_leave = lv; launch_guest = lg;
    w = en ? want_enter() : (lv ? want_leave() : -1);
    @(posedge clk);
    @(negedge clk);
    req_enter = 0; req_leave = 0; launch_guest = 0;
    succ = 0;
    if (w >= 0) begin
      succ = (w == 5);
      if (w == 5 && en) begin m_mode = 2'b01; m_ptr = '1; m_init = 1; m_a20 = 1; end
      else if (w == 5) begin m_mode = 2'b00; m_init = 0; m_a20 = 0; end
      else if (w == 2) m_mode = 2'b01;
      chk({tag, " R2 done"}, done, 1);
      chk({tag, " R2 result"}, result, 64'h1 << w);
    end else begin
      if (lg && m_mode == 2'b01) m_mode = 2'b10;
      chk({tag, " R2 idle done"}, done, 0);
      chk({tag, " R2 idle result"}, result, 0);
    end
    chk({tag, " mode"}, mode, m_mode);
    chk({tag, " R8 init"}, init_blocked, m_init);
    chk({tag, " R8 a20"}, a20_disabled, m_a20);
    chk({tag, " R13 mon_clear"}, mon_clear, succ);
    chk({tag, " R13 cur_ptr"}, cur_ptr, m_ptr);
  endtask

  task automatic good_inputs();
    cpl = 0; v86 = 0; long_mode = 1; cs_long = 1; operand_is_reg = 0;
    cr4_enable = 1; cr0_pe = 1; a20m_active = 0; fixed_ok = 1; feat_ctrl = 8'hFF;
    dual_mon = 0; core_64 = 1; region_ptr = 64'h0000_0123_4567_8000; rev_word = REV;
  endtask

  task automatic rand_inputs();
    good_inputs();
    if ($urandom % 14 == 0) cpl = 2'($urandom % 3 + 1);
    if ($urandom % 20 == 0) v86 = 1;
    long_mode = 1'($urandom);
    cs_long = ($urandom % 10 != 0);
    if ($urandom % 20 == 0) operand_is_reg = 1;
    if ($urandom % 20 == 0) cr4_enable = 0;
    if ($urandom % 20 == 0) cr0_pe = 0;
    if ($urandom % 20 == 0) a20m_active = 1;
    if ($urandom % 20 == 0) fixed_ok = 0;
    feat_ctrl = ($urandom % 6 == 0) ? 8'($urandom) : 8'hFF;
    dual_mon = ($urandom % 5 == 0);
    core_64 = ($urandom % 4 != 0);
    case ($urandom % 8)
      0: region_ptr = {$urandom, $urandom};
      1: region_ptr = 64'h1 << ($urandom % 64);
      2: region_ptr = {20'h0, 32'($urandom), 12'h0};
      default: region_ptr = {32'h0, 20'($urandom), 12'h0};
    endcase
    if ($urandom % 8 == 0) rev_word = $urandom;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    chk("R1 init", init_blocked, 0);
    chk("R1 a20", a20_disabled, 0);
    chk("R1 mon_clear", mon_clear, 0);
    chk("R1 cur_ptr", cur_ptr, 0);

    good_inputs();
    issue(0, 1, 0, "R10 leave outside ud");
    issue(0, 0, 1, "R11 launch outside ignored");
    v86 = 1; cpl = 3; issue(1, 0, 0, "R3 v86 beats cpl"); good_inputs();
    long_mode = 1; cs_long = 0; issue(1, 0, 0, "R3 compat mode"); good_inputs();
    operand_is_reg = 1; cpl = 1; issue(1, 0, 0, "R4 reg operand"); good_inputs();
    cr4_enable = 0; issue(1, 0, 0, "R4 cr4"); good_inputs();
    cr0_pe = 0; issue(1, 0, 0, "R4 pe"); good_inputs();
    feat_ctrl = 8'hFE; issue(1, 0, 0, "R5 lock bit"); good_inputs();
    feat_ctrl = 8'hFB; issue(1, 0, 0, "R5 enable bit"); good_inputs();
    a20m_active = 1; issue(1, 0, 0, "R5 a20m"); good_inputs();
    fixed_ok = 0; issue(1, 0, 0, "R5 fixed"); good_inputs();
    region_ptr = 64'h1008; issue(1, 0, 0, "R6 misaligned"); good_inputs();
    region_ptr = 64'h1 << PA_W; issue(1, 0, 0, "R6 pa width"); good_inputs();
    core_64 = 0; region_ptr = 64'h100_0000_0000; issue(1, 0, 0, "R6 32bit hi"); good_inputs();
    rev_word = REV ^ 32'h1; issue(1, 0, 0, "R7 revision"); good_inputs();
    feat_ctrl = 8'h05; region_ptr = (64'h1 << (PA_W - 1)) | 64'h1000;
    issue(1, 0, 0, "R8 enter success"); good_inputs();
    issue(1, 0, 0, "R9 enter in root");
    cpl = 3; issue(1, 0, 0, "R9 enter root cpl"); good_inputs();
    issue(1, 0, 1, "R11 launch with request ignored");
    issue(0, 0, 1, "R11 launch");
    issue(1, 0, 0, "R9 enter guest trap");
    issue(0, 0, 1, "R11 launch again");
    issue(0, 1, 0, "R10 leave guest trap");
    cpl = 2; dual_mon = 1; issue(0, 1, 0, "R10 leave cpl beats dual"); good_inputs();
    dual_mon = 1; issue(0, 1, 0, "R10 leave dual"); good_inputs();
    issue(0, 1, 0, "R10 leave success");
    issue(1, 1, 0, "R12 both strobes");
    issue(1, 1, 0, "R12 both in root");

    for (int n = 0; n < 3000; n++) begin
      rand_inputs();
      case ($urandom % 6)
        0: issue(1, 0, 0, "R5 R6 R7 rnd enter");
        1: issue(0, 1, 0, "R10 rnd leave");
        2: issue(1, 1, 0, "R12 rnd both");
        3: issue(0, 0, 1, "R11 rnd launch");
        4: issue(1, 0, 1, "R9 rnd enter launch");
        default: issue(0, 0, 0, "R2 rnd idle");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule